// File: doc/BRIEF.md
# Ripple-Grant Bus Arbiter

This block decides which of several devices may use a shared bus. Every device's request is folded into one combined request line, and the control logic sees only that line and the release strobes. When the bus is free and the combined line is high, the control logic issues a single grant. That grant enters the first stage of a chain of pass/take cells, one cell per device.

A cell whose device is requesting keeps the grant. A cell whose device is not requesting hands the grant to the next cell. Device 0 sits nearest the control logic and always wins over devices further down. The device that took the grant owns the bus until it pulses its release line. Only after that can a new grant enter the chain.

Nothing in the scheme is fair. A device deep in the chain can wait forever while devices closer to the control logic keep asking for the bus. The grant path is serial, so the depth of the chain sets how short the clock period can be.

Top module: `daisy_arbiter`

## Requirements
- R1: After reset, every bit of `dev_own` is 0 and `bus_busy` is 0.
- R2: While idle, a request from any single device makes that device the owner on the next clock edge. Ownership is shown as `dev_own` bit k = 1 for device k, and `bus_busy` = 1.
- R3: When several devices request while idle, the device with the lowest index takes the grant. Bit 0 is nearest the control logic.
- R4: While `bus_busy` is 1, exactly one bit of `dev_own` is 1. While `bus_busy` is 0, no bit of `dev_own` is 1.
- R5: While busy, the owner does not change. This holds even if a device of higher priority raises its request, or if the owner drops its own request.
- R6: A release pulse from the current owner returns the block to idle on the next clock edge. `bus_busy` becomes 0 and `dev_own` becomes all zero.
- R7: A release pulse from any device that is not the current owner has no effect. The owner and `bus_busy` stay unchanged.
- R8: In the cycle after a release, no device owns the bus, even if requests are pending. A new grant is taken at the following edge, again by the lowest-index requester. A high-index device therefore waits as long as a lower index keeps requesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dev_req | input | N_DEV | Per-device bus request |
| dev_rel | input | N_DEV | Per-device release strobe |
| dev_own | output | N_DEV | Per-device grant taken (bus ownership) |
| bus_busy | output | 1 | High while some device owns the bus |

## Verification
The hardest situation to reach from the ports is a grant that ripples past idle devices while a higher-priority device appears in the middle of an ownership. The stimulus first hands the bus to the last device alone. It then raises device 0's request and drops the owner's request, and shows that ownership stays put. Finally the owner releases, and the stimulus checks the empty cycle that follows before device 0 takes the bus. A separate scenario keeps device 0 requesting across several rounds to show that the last device is starved. Foreign release pulses are driven from several non-owners at once.

// File: rtl/dchain_pkg.sv
package dchain_pkg;
    typedef enum logic {
        ARB_IDLE = 1'b0,
        ARB_BUSY = 1'b1
    } arb_state_e;
endpackage

// File: rtl/dchain_cell.sv
// One pass/take stage of the grant chain.
module dchain_cell (
    input  logic grant_in,
    input  logic req,
    output logic take,
    output logic grant_out
);
    always_comb begin
        take      = grant_in & req;
        grant_out = grant_in & ~req;
    end
endmodule

// File: rtl/dchain_ctrl.sv
// Control logic: sees only the combined request and the release strobes.
module dchain_ctrl #(
    parameter int N_DEV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             any_req,
    input  logic [N_DEV-1:0] take_vec,
    input  logic [N_DEV-1:0] rel,
    output logic             grant_issue,
    output logic [N_DEV-1:0] owner,
    output logic             busy
);
    import dchain_pkg::*;

    typedef struct packed {
        arb_state_e       st;
        logic [N_DEV-1:0] own;
    } ctrl_s;

    ctrl_s ctrl_d, ctrl_q;
    logic  rel_hit;

    always_comb begin
        ctrl_d      = ctrl_q;
        rel_hit     = |(rel & ctrl_q.own);
        grant_issue = (ctrl_q.st == ARB_IDLE) && any_req;
        case (ctrl_q.st)
            ARB_IDLE: begin
                if (grant_issue) begin
                    ctrl_d.st  = ARB_BUSY;
                    ctrl_d.own = take_vec;
                end
            end
            ARB_BUSY: begin
                if (rel_hit) begin
                    ctrl_d.st  = ARB_IDLE;
                    ctrl_d.own = '0;
                end
            end
            default: ctrl_d = '{st: ARB_IDLE, own: '0};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '{st: ARB_IDLE, own: '0};
        else        ctrl_q <= ctrl_d;
    end

    assign owner = ctrl_q.own;
    assign busy  = (ctrl_q.st == ARB_BUSY);

    // R6: owner's release frees the bus on the next edge
    p_release_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && |(rel & owner)) |=> (!busy && owner == '0));

    // R5, R7: without an owner release, ownership holds
    p_hold_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(|(rel & owner))) |=> (busy && $stable(owner)));
endmodule

// File: rtl/daisy_arbiter.sv
module daisy_arbiter #(
    parameter int N_DEV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_DEV-1:0] dev_req,
    input  logic [N_DEV-1:0] dev_rel,
    output logic [N_DEV-1:0] dev_own,
    output logic             bus_busy
);
    logic             any_req;
    logic             grant_issue;
    logic [N_DEV:0]   grant_chain;
    logic [N_DEV-1:0] take_vec;

    assign any_req        = |dev_req;
    assign grant_chain[0] = grant_issue;

    for (genvar k = 0; k < N_DEV; k++) begin : g_stage
        dchain_cell u_cell (
            .grant_in  (grant_chain[k]),
            .req       (dev_req[k]),
            .take      (take_vec[k]),
            .grant_out (grant_chain[k+1])
        );
    end

    dchain_ctrl #(.N_DEV(N_DEV)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .any_req     (any_req),
        .take_vec    (take_vec),
        .rel         (dev_rel),
        .grant_issue (grant_issue),
        .owner       (dev_own),
        .busy        (bus_busy)
    );

    // R4: one owner while busy, none while idle
    p_onehot_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_busy ? $onehot(dev_own) : (dev_own == '0));

    // R2: an idle request is served on the next edge
    p_grant_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_busy && any_req) |=> bus_busy);

    // R3: device 0 wins whenever it asks while idle
    p_head_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_busy && dev_req[0]) |=> dev_own[0]);

    // R3: the chain never yields more than one taker
    p_chain_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(take_vec));
endmodule

// File: tb/daisy_arbiter_tb.sv
module daisy_arbiter_tb_top;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] dev_req = '0;
    logic [N-1:0] dev_rel = '0;
    logic [N-1:0] dev_own;
    logic         bus_busy;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    daisy_arbiter #(.N_DEV(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .dev_rel(dev_rel),
        .dev_own(dev_own), .bus_busy(bus_busy)
    );

    task automatic check(input string tag, input logic [N:0] act, input logic [N:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // advance one edge, sample at the falling edge, check R4 consistency
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        n_chk++;
        if (bus_busy ? ($countones(dev_own) != 1) : (dev_own != '0)) begin
            n_fail++;
            $display("FAIL R4 actual=%b/%b expected=onehot-iff-busy", bus_busy, dev_own);
        end
    endtask

    task automatic release_from(input int k);
        dev_rel = '0;
        dev_rel[k] = 1'b1;
        step();
        dev_rel = '0;
    endtask

    task automatic t_reset();
        check("R1 reset", {bus_busy, dev_own}, '0);
    endtask

    task automatic t_single();
        for (int k = 0; k < N; k++) begin
            dev_req = '0;
            dev_req[k] = 1'b1;
            step();
            check("R2 single grant", {bus_busy, dev_own}, {1'b1, N'(1 << k)});
            dev_req = '0;
            release_from(k);
            check("R6 release idle", {bus_busy, dev_own}, '0);
        end
    endtask

    task automatic t_priority();
        dev_req = 4'b1010;
        step();
        check("R3 priority 1010", {bus_busy, dev_own}, {1'b1, 4'b0010});
        dev_req = '0;
        release_from(1);
        dev_req = 4'b1100;
        step();
        check("R3 priority 1100", {bus_busy, dev_own}, {1'b1, 4'b0100});
        dev_req = '0;
        release_from(2);
        check("R6 after priority", {bus_busy, dev_own}, '0);
    endtask

    task automatic t_no_preempt();
        dev_req = 4'b1000;
        step();
        check("R2 tail owner", {bus_busy, dev_own}, {1'b1, 4'b1000});
        dev_req = 4'b1001;
        step();
        check("R5 no preempt", {bus_busy, dev_own}, {1'b1, 4'b1000});
        dev_req = 4'b0001;
        step();
        check("R5 owner drop req", {bus_busy, dev_own}, {1'b1, 4'b1000});
        release_from(3);
        check("R8 gap after release", {bus_busy, dev_own}, '0);
        step();
        check("R8 next grant", {bus_busy, dev_own}, {1'b1, 4'b0001});
        dev_req = '0;
        release_from(0);
    endtask

    task automatic t_foreign();
        dev_req = 4'b0010;
        step();
        dev_req = '0;
        dev_rel = 4'b1101;
        step();
        check("R7 foreign release", {bus_busy, dev_own}, {1'b1, 4'b0010});
        dev_rel = 4'b0001;
        step();
        check("R7 foreign single", {bus_busy, dev_own}, {1'b1, 4'b0010});
        dev_rel = '0;
        release_from(1);
        check("R6 owner release", {bus_busy, dev_own}, '0);
    endtask

    task automatic t_starve();
        dev_req = 4'b1001;
        for (int r = 0; r < 3; r++) begin
            step();
            check("R8 head keeps winning", {bus_busy, dev_own}, {1'b1, 4'b0001});
            release_from(0);
            check("R8 idle gap", {bus_busy, dev_own}, '0);
        end
        dev_req = 4'b1000;
        step();
        check("R8 tail served last", {bus_busy, dev_own}, {1'b1, 4'b1000});
        dev_req = '0;
        release_from(3);
    endtask

    initial begin
        #1;
        t_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_priority();
        t_no_preempt();
        t_foreign();
        t_starve();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule